// File: doc/BRIEF.md
# Packet-Granular Round-Robin Port Arbiter

This block decides which of four receive ports may use the single fabric datapath that they share. The datapath is clocked at four times the line rate, so a fixed cyclic scan is enough to serve all four ports fairly. The controller examines one port per clock. When the examined port reports that its length queue holds a packet, the controller hands the datapath to that port. It keeps the grant until the downstream packet handler signals that the packet is complete. The scan then resumes at the following port, so a port that has just finished never goes again straight away.

The controller has eight states: an examine state and a grant state for each port. The grant is shown three ways: a one-hot port select, the number of the current port, and a ready strobe that the handler uses as its start-of-service handshake. Frame storage, data movement and packet validation belong to the surrounding logic.

Top module: `rr_pkt_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the controller examines port 0: `connReady` is 0, `connSel` is 4'b0000 and `connPort` is 0.
- R2: In an examine state whose port has its `lenNotEmpty` bit set to 1, the next cycle is the grant state of the same port.
- R3: In an examine state whose port has its `lenNotEmpty` bit at 0, the next cycle examines the next port. Each empty port costs exactly one clock.
- R4: In a grant state, the controller stays on the same port for every cycle in which `pktDone` is 0.
- R5: In a grant state, `pktDone` = 1 moves the controller on the next cycle to the examine state of the next port. Port 3 is followed by port 0.
- R6: `pktDone` has no effect in examine states.
- R7: `connReady` is 1 in exactly the grant cycles. `connSel` is zero in examine states and has only bit p set while port p holds the grant.
- R8: `connPort` always carries the number of the port currently being examined or served (0 to 3).
- R9: Only the `lenNotEmpty` bit of the examined port affects the scan. The bits of other ports are ignored, and so are all bits during a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (four times the line rate) |
| rstN | input | 1 | Active-low synchronous reset |
| lenNotEmpty | input | 4 | Per-port flag: the length queue holds at least one packet |
| pktDone | input | 1 | Handler reports the end of the packet in service |
| connSel | output | 4 | One-hot select of the port holding the grant |
| connPort | output | 2 | Number of the port being examined or served |
| connReady | output | 1 | High in every cycle of a grant |

## Verification
The hardest cases to reach are the ones where the flags of unpolled ports and a stray `pktDone` happen in the same cycle as a decision. Examples are a `pktDone` pulse in the cycle when an empty port is being examined, and a busy neighbour while the examined port is empty. The stimulus covers these with directed sequences first: all ports idle, a single busy port, every port busy with one-cycle packets across the 3-to-0 wrap, and done pulses while scanning. Long random runs follow, in which the flags and `pktDone` are drawn independently on every cycle. The bench model steps alongside and is compared on every clock.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_W    = $clog2(NUM_PORTS);

  typedef enum logic {PH_CHECK = 1'b0, PH_GRANT = 1'b1} phase_t;

  typedef struct packed {
    logic              grantActive;
    logic [PORT_W-1:0] portIdx;
  } arbStrobes_t;

  function automatic logic [PORT_W-1:0] nextPort(input logic [PORT_W-1:0] p);
    return (p == PORT_W'(NUM_PORTS - 1)) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/rr_arb_ctrl.sv
module rr_arb_ctrl
  import rr_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] lenNotEmpty,
  input  logic                 pktDone,
  output arbStrobes_t          strobes
);
  phase_t            phase, phaseNext;
  logic [PORT_W-1:0] curPort, curPortNext;
  logic              polledBusy;

  assign polledBusy = lenNotEmpty[curPort];

  always_comb begin
    phaseNext   = phase;
    curPortNext = curPort;
    unique case (phase)
      PH_CHECK: begin
        if (polledBusy) phaseNext = PH_GRANT;
        else            curPortNext = nextPort(curPort);
      end
      PH_GRANT: begin
        if (pktDone) begin
          phaseNext   = PH_CHECK;
          curPortNext = nextPort(curPort);
        end
      end
      default: phaseNext = PH_CHECK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_CHECK;
      curPort <= '0;
    end else begin
      phase   <= phaseNext;
      curPort <= curPortNext;
    end
  end

  assign strobes.grantActive = (phase == PH_GRANT);
  assign strobes.portIdx     = curPort;

  // R2: a busy polled port is granted next cycle, same port
  a_r2_grant_same_port: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CHECK && lenNotEmpty[curPort]) |=>
      (phase == PH_GRANT && curPort == $past(curPort)));

  // R3 and R6: an empty polled port is skipped in one clock, pktDone irrelevant
  a_r3_skip_empty: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CHECK && !lenNotEmpty[curPort]) |=>
      (phase == PH_CHECK && curPort == nextPort($past(curPort))));

  // R4: grant is held while the packet is unfinished
  a_r4_hold_grant: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_GRANT && !pktDone) |=> (phase == PH_GRANT && $stable(curPort)));

  // R5: end of packet advances to examine the following port
  a_r5_advance_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_GRANT && pktDone) |=>
      (phase == PH_CHECK && curPort == nextPort($past(curPort))));
endmodule

// File: rtl/rr_arb_datapath.sv
module rr_arb_datapath
  import rr_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrobes_t          strobes,
  output logic [NUM_PORTS-1:0] connSel,
  output logic [PORT_W-1:0]    connPort,
  output logic                 connReady
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
    assign connSel[i] = strobes.grantActive && (strobes.portIdx == PORT_W'(i));
  end

  assign connPort  = strobes.portIdx;
  assign connReady = strobes.grantActive;

  // R7: at most one port selected, and a select exists exactly when ready
  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(connSel) && (connReady == (connSel != '0)));

  // R7: the selected bit is the reported port number
  a_r7_sel_matches_port: assert property (@(posedge clk) disable iff (!rstN)
    connReady |-> connSel[connPort]);
endmodule

// File: rtl/rr_pkt_arbiter.sv
module rr_pkt_arbiter
  import rr_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] lenNotEmpty,
  input  logic                 pktDone,
  output logic [NUM_PORTS-1:0] connSel,
  output logic [PORT_W-1:0]    connPort,
  output logic                 connReady
);
  arbStrobes_t strobes;

  rr_arb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lenNotEmpty (lenNotEmpty),
    .pktDone     (pktDone),
    .strobes     (strobes)
  );

  rr_arb_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .connSel   (connSel),
    .connPort  (connPort),
    .connReady (connReady)
  );

  // R1: first cycle after reset examines port 0
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (!connReady && connPort == '0 && connSel == '0));
endmodule

// File: tb/tb_rr_pkt_arbiter.sv
module tb_rr_pkt_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] lenNotEmpty = 4'b0;
  logic       pktDone = 1'b0;
  logic [3:0] connSel;
  logic [1:0] connPort;
  logic       connReady;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model: granted flag and port number
  bit    mGrant = 0;
  int    mPort  = 0;
  string lastReq = "R1";

  always #5 clk = ~clk;

  rr_pkt_arbiter dut (
    .clk(clk), .rstN(rstN), .lenNotEmpty(lenNotEmpty), .pktDone(pktDone),
    .connSel(connSel), .connPort(connPort), .connReady(connReady)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mGrant = 0; mPort = 0; lastReq = "R1";
    end else if (!mGrant) begin
      if (lenNotEmpty[mPort]) begin
        mGrant = 1; lastReq = "R2";
      end else begin
        if (pktDone)               lastReq = "R6";
        else if (lenNotEmpty != 0) lastReq = "R9";
        else                       lastReq = "R3";
        mPort = (mPort + 1) % 4;
      end
    end else begin
      if (pktDone) begin
        mGrant = 0; mPort = (mPort + 1) % 4; lastReq = "R5";
      end else begin
        lastReq = (lenNotEmpty != 0) ? "R9" : "R4";
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] expSel;
    expSel = mGrant ? (4'b0001 << mPort) : 4'b0000;
    compared++;
    if (connReady !== mGrant) begin
      mismatched++;
      $display("FAIL %s/R7 connReady: actual %0d expected %0d", lastReq, connReady, mGrant);
    end
    compared++;
    if (connSel !== expSel) begin
      mismatched++;
      $display("FAIL %s/R7 connSel: actual %b expected %b", lastReq, connSel, expSel);
    end
    compared++;
    if (connPort !== 2'(mPort)) begin
      mismatched++;
      $display("FAIL %s/R8 connPort: actual %0d expected %0d", lastReq, connPort, mPort);
    end
  end

  task automatic step(input logic [3:0] flags, input logic done);
    @(negedge clk);
    lenNotEmpty = flags;
    pktDone     = done;
  endtask

  initial begin
    // R1: hold reset for a few cycles
    repeat (3) step(4'b1111, 1'b1);
    step(4'b0000, 1'b0);
    rstN = 1'b1;
    // R3: all idle, one clock per port including the wrap
    repeat (9) step(4'b0000, 1'b0);
    // R6: done pulses while scanning idle ports
    repeat (5) step(4'b0000, 1'b1);
    // R2, R4, R5, R9: only port 2 busy, packet of several cycles
    repeat (4) step(4'b0100, 1'b0);
    repeat (5) step(4'b1011, 1'b0);
    step(4'b0000, 1'b1);
    // R5: every port busy with one-cycle packets across the 3 to 0 wrap
    repeat (16) step(4'b1111, 1'b1);
    // R9: busy neighbours while the polled port is empty
    repeat (12) step(4'b1010, 1'b0);
    step(4'b1010, 1'b1);
    repeat (6) step(4'b0101, 1'b0);
    // random run
    for (int i = 0; i < 3000; i++)
      step(4'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0));
    // mid-run reset, R1 again
    step(4'b1111, 1'b0);
    rstN = 1'b0;
    repeat (2) step(4'b1111, 1'b0);
    rstN = 1'b1;
    repeat (10) step(4'b0001, 1'b0);
    step(4'b0000, 1'b0);
    @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule